// File: doc/BRIEF.md
# Masked-Compare Chip-Select Decoder

This block turns a 21-bit external byte address into three active-low chip-select lines. Each line has a base register and a mask register. Both registers cover only the upper address bits, 20 down to 8. A line matches when every address bit whose mask bit is one equals the base bit in the same position. Address bits whose mask bit is zero are free, so a window always spans a power of two bytes. To size a window of 2^n bytes, set the top 21 − n mask bits and clear the rest. The smallest window is 256 bytes.

After reset, select 0 already covers the 256-byte page 1F2000–1F20FF. That page holds the boot configuration bytes and the first instruction fetch, so the boot fetch can use select 0 with no setup. Selects 1 and 2 stay silent until software loads them through the write port and turns them on. When several enabled windows contain the same address, only the lowest-numbered select goes low.

The decode is registered. An address presented with its valid strobe high before a clock edge drives the selects during the following cycle. A cycle without the strobe leaves all selects high.

Top module: `csd_decode_top`

## Requirements
- R1: After reset, all selects are high. Select 0 is enabled with base 1F20h and mask 1FFFh, so it covers addresses 1F2000h–1F20FFh. Selects 1 and 2 are disabled with mask and base at zero.
- R2: An enabled select matches when (addr[20:8] XOR base) AND mask is zero. An address outside that window does not drive it.
- R3: Address bits 7:0 never affect a match.
- R4: Base 17E0h with mask 1FE0h covers exactly 17E000h–17FFFFh, a window of 8 Kbytes.
- R5: Base 1800h with mask 1800h covers exactly 180000h–1FFFFFh, a window of 512 Kbytes.
- R6: Base 101Eh with mask 1FFFh covers exactly 101E00h–101EFFh, a window of 256 bytes.
- R7: At most one select is low at a time. When several enabled windows match, the lowest index wins.
- R8: A select is low only in the cycle after an edge at which the address-valid strobe was high.
- R9: The selects show the decode of the address and configuration sampled at the previous clock edge. A write's new value applies to addresses sampled at later edges.
- R10: The write port takes wr_cs_i (select index) and wr_fld_i (0 = base, 1 = mask, 2 = enable from wr_data_i[0]). Field code 3 and a select index of 3 change nothing.
- R11: A disabled select never goes low, whatever its base and mask hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 21 | External byte address |
| addr_vld_i | input | 1 | Address-valid strobe |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_cs_i | input | 2 | Select index being written |
| wr_fld_i | input | 2 | Field code: 0 base, 1 mask, 2 enable, 3 none |
| wr_data_i | input | 13 | Write data; the enable field uses bit 0 |
| cs_n_o | output | 3 | Active-low chip selects, bit i is select i |

## Verification
Every select result is due exactly one clock after the edge that samples its address and strobe. A configuration write affects the first address sampled at the edge after the write edge. The driver changes inputs on the falling edge. For each cycle it queues the expected select pattern, computed from its own copy of the configuration as it stood before that edge's write. The monitor takes one entry off the queue a quarter period after each rising edge, so every comparison falls in the one cycle where its result is valid.

// File: rtl/csd_pkg.sv
package csd_pkg;
   // Field codes on the configuration write port
   typedef enum logic [1:0] {
      FLD_BASE = 2'd0,
      FLD_MASK = 2'd1,
      FLD_EN   = 2'd2,
      FLD_NONE = 2'd3
   } csd_fld_e;
endpackage

// File: rtl/csd_cfg_bank.sv
module csd_cfg_bank
   import csd_pkg::*;
#(
   parameter int NUM_CS = 3,
   parameter int REG_W  = 13,
   parameter int SEL_W  = 2,
   parameter logic [REG_W-1:0] RST_BASE0 = '0,
   parameter logic [REG_W-1:0] RST_MASK0 = '1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [SEL_W-1:0]             wr_cs,
   input  logic [1:0]                   wr_fld,
   input  logic [REG_W-1:0]             wr_data,
   output logic [NUM_CS-1:0][REG_W-1:0] base_o,
   output logic [NUM_CS-1:0][REG_W-1:0] mask_o,
   output logic [NUM_CS-1:0]            en_o
);
   csd_fld_e fld;
   assign fld = csd_fld_e'(wr_fld);

   for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
      // Select 0 comes out of reset covering the boot page; the others are off
      localparam logic [REG_W-1:0] RB = (g == 0) ? RST_BASE0 : '0;
      localparam logic [REG_W-1:0] RM = (g == 0) ? RST_MASK0 : '0;
      localparam logic             RE = (g == 0);

      logic hit;
      assign hit = wr_en && (wr_cs == SEL_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_o[g] <= RB;
            mask_o[g] <= RM;
            en_o[g]   <= RE;
         end else if (hit) begin
            unique case (fld)
               FLD_BASE: base_o[g] <= wr_data;
               FLD_MASK: mask_o[g] <= wr_data;
               FLD_EN:   en_o[g]   <= wr_data[0];
               FLD_NONE: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/csd_window_match.sv
module csd_window_match #(
   parameter int REG_W = 13
) (
   input  logic [REG_W-1:0] page,
   input  logic [REG_W-1:0] base,
   input  logic [REG_W-1:0] mask,
   input  logic             en,
   output logic             hit
);
   // Only bit positions with a set mask take part in the compare
   logic [REG_W-1:0] diff;
   assign diff = (page ^ base) & mask;
   assign hit  = en && (diff == '0);
endmodule

// File: rtl/csd_lowest_first.sv
module csd_lowest_first #(
   parameter int N = 3
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   always_comb begin
      logic taken;
      taken = 1'b0;
      gnt   = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !taken) begin
            gnt[i] = 1'b1;
            taken  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/csd_decode_top.sv
module csd_decode_top
   import csd_pkg::*;
#(
   parameter int ADDR_W   = 21,
   parameter int PAGE_LSB = 8,
   parameter int NUM_CS   = 3,
   parameter int SEL_W    = 2,
   parameter logic [ADDR_W-PAGE_LSB-1:0] RST_BASE0 = 13'h1F20,
   parameter logic [ADDR_W-PAGE_LSB-1:0] RST_MASK0 = 13'h1FFF
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic                       addr_vld_i,
   input  logic                       wr_en_i,
   input  logic [SEL_W-1:0]           wr_cs_i,
   input  logic [1:0]                 wr_fld_i,
   input  logic [ADDR_W-PAGE_LSB-1:0] wr_data_i,
   output logic [NUM_CS-1:0]          cs_n_o
);
   localparam int REG_W = ADDR_W - PAGE_LSB;

   if (PAGE_LSB < 1 || PAGE_LSB >= ADDR_W) begin : g_bad_lsb
      $error("csd_decode_top: PAGE_LSB must lie inside the address");
   end
   if (NUM_CS < 1 || NUM_CS > (1 << SEL_W)) begin : g_bad_cs
      $error("csd_decode_top: NUM_CS must fit the select index width");
   end

   logic [NUM_CS-1:0][REG_W-1:0] cfg_base;
   logic [NUM_CS-1:0][REG_W-1:0] cfg_mask;
   logic [NUM_CS-1:0]            cfg_en;
   logic [REG_W-1:0]             page;
   logic [NUM_CS-1:0]            req;
   logic [NUM_CS-1:0]            gnt;
   logic [NUM_CS-1:0]            sel_q;

   assign page = addr_i[ADDR_W-1:PAGE_LSB];

   csd_cfg_bank #(
      .NUM_CS(NUM_CS), .REG_W(REG_W), .SEL_W(SEL_W),
      .RST_BASE0(RST_BASE0), .RST_MASK0(RST_MASK0)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en_i), .wr_cs(wr_cs_i), .wr_fld(wr_fld_i), .wr_data(wr_data_i),
      .base_o(cfg_base), .mask_o(cfg_mask), .en_o(cfg_en)
   );

   for (genvar g = 0; g < NUM_CS; g++) begin : g_win
      csd_window_match #(.REG_W(REG_W)) u_match (
         .page(page), .base(cfg_base[g]), .mask(cfg_mask[g]),
         .en(cfg_en[g]), .hit(req[g])
      );
   end

   csd_lowest_first #(.N(NUM_CS)) u_pick (.req(req), .gnt(gnt));

   // Registered decode, gated by the valid strobe sampled at the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else        sel_q <= addr_vld_i ? gnt : '0;
   end

   assign cs_n_o = ~sel_q;
endmodule

// File: rtl/csd_decode_chk.sv
module csd_decode_chk #(
   parameter int NUM_CS = 3,
   parameter int REG_W  = 13
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         addr_vld,
   input logic [NUM_CS-1:0]            cs_n,
   input logic [NUM_CS-1:0]            en,
   input logic [NUM_CS-1:0][REG_W-1:0] mask
);
   p_single_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   p_strobe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(addr_vld) |-> (&cs_n));

   // Select 0 wins every tie, so with a zero mask it must fire on any valid address
   p_open_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(addr_vld && en[0] && (mask[0] == '0)) |-> !cs_n[0]);

   for (genvar g = 0; g < NUM_CS; g++) begin : g_off
      p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
         $past(!en[g]) |-> cs_n[g]);
   end
endmodule

bind csd_decode_top csd_decode_chk #(.NUM_CS(NUM_CS), .REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld_i),
   .cs_n(cs_n_o), .en(cfg_en), .mask(cfg_mask)
);

// File: tb/tb_csd_decode_top.sv
module tb_csd_decode_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [20:0] addr = '0;
   logic        vld = 1'b0;
   logic        we = 1'b0;
   logic [1:0]  wcs = '0;
   logic [1:0]  wfld = '0;
   logic [12:0] wdat = '0;
   logic [2:0]  cs_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [2:0] exp_q[$];
   string      tag_q[$];

   logic [12:0] m_base [3];
   logic [12:0] m_mask [3];
   logic        m_en   [3];

   always #(CLK_PERIOD/2) clk = ~clk;

   csd_decode_top dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .addr_vld_i(vld),
      .wr_en_i(we), .wr_cs_i(wcs), .wr_fld_i(wfld), .wr_data_i(wdat),
      .cs_n_o(cs_n)
   );

   function automatic logic [2:0] model_cs_n(input logic [20:0] a, input logic v);
      logic [2:0] r;
      r = 3'b111;
      if (v) begin
         for (int i = 0; i < 3; i++) begin
            if (m_en[i] && (((a[20:8] ^ m_base[i]) & m_mask[i]) == 13'h0)) begin
               r[i] = 1'b0;
               break;
            end
         end
      end
      return r;
   endfunction

   task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: cs_n=%b expected %b", tag, act, exp);
      end
   endtask

   // One bus cycle: drive, queue expected result, then mirror any write
   task automatic step(input logic [20:0] a, input logic v, input logic w,
                       input logic [1:0] c, input logic [1:0] f,
                       input logic [12:0] d, input string tag);
      @(negedge clk);
      addr = a; vld = v; we = w; wcs = c; wfld = f; wdat = d;
      exp_q.push_back(model_cs_n(a, v));
      tag_q.push_back(tag);
      if (w && c < 2'd3) begin
         case (f)
            2'd0: m_base[c] = d;
            2'd1: m_mask[c] = d;
            2'd2: m_en[c]   = d[0];
            default: ;
         endcase
      end
   endtask

   task automatic look(input logic [20:0] a, input string tag);
      step(a, 1'b1, 1'b0, 2'd0, 2'd0, 13'h0, tag);
   endtask

   task automatic cfg(input logic [1:0] c, input logic [1:0] f,
                      input logic [12:0] d, input string tag);
      step(21'h0, 1'b0, 1'b1, c, f, d, tag);
   endtask

   // Monitor: compares one queued expectation per cycle, away from the edge
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_PERIOD/4);
         if (exp_q.size() > 0) check(cs_n, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      m_base[0] = 13'h1F20; m_mask[0] = 13'h1FFF; m_en[0] = 1'b1;
      for (int i = 1; i < 3; i++) begin
         m_base[i] = '0; m_mask[i] = '0; m_en[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      check(cs_n, 3'b111, "R1 reset outputs");
      rst_n = 1'b1;

      look(21'h1F2000, "R1 boot page start");
      look(21'h1F20FF, "R3 boot page low byte free");
      look(21'h1F2100, "R2 outside boot page");
      step(21'h1F2000, 1'b0, 1'b0, 2'd0, 2'd0, 13'h0, "R8 strobe low");
      look(21'h1F2080, "R9 back to back after idle");
      look(21'h17E000, "R11 select 2 off after reset");
      look(21'h180000, "R11 select 1 off after reset");

      cfg(2'd2, 2'd0, 13'h17E0, "R10 write base 2");
      cfg(2'd2, 2'd1, 13'h1FE0, "R10 write mask 2");
      cfg(2'd2, 2'd2, 13'h0001, "R10 enable 2");
      look(21'h17E000, "R4 8K low end");
      look(21'h17FFFF, "R4 8K high end");
      look(21'h17DFFF, "R4 below 8K");
      look(21'h180000, "R4 above 8K");

      cfg(2'd1, 2'd0, 13'h1800, "R10 write base 1");
      cfg(2'd1, 2'd1, 13'h1800, "R10 write mask 1");
      // enable write and a lookup at the very next edge: R9 ordering
      step(21'h180000, 1'b1, 1'b1, 2'd1, 2'd2, 13'h0001, "R9 write not yet visible");
      look(21'h180000, "R5 512K low end");
      look(21'h1FFFFF, "R5 512K high end");
      look(21'h17FFFF, "R5 below 512K");

      cfg(2'd0, 2'd0, 13'h101E, "R10 write base 0");
      look(21'h101E00, "R6 256B low end");
      look(21'h101EFF, "R6 256B high end");
      look(21'h101F00, "R6 above 256B");
      look(21'h101DFF, "R6 below 256B");

      cfg(2'd0, 2'd0, 13'h1800, "R10 base 0 wide");
      cfg(2'd0, 2'd1, 13'h1000, "R10 mask 0 wide");
      look(21'h180000, "R7 select 0 beats 1");
      look(21'h17E000, "R7 select 0 beats 2");
      look(21'h0FFFFF, "R2 bit20 clear misses");

      cfg(2'd0, 2'd2, 13'h0000, "R10 disable 0");
      look(21'h180000, "R11 disabled 0, select 1 wins");
      look(21'h17E000, "R7 select 2 alone");

      cfg(2'd1, 2'd3, 13'h0000, "R10 field 3");
      step(21'h0, 1'b0, 1'b1, 2'd3, 2'd2, 13'h0001, "R10 index 3");
      step(21'h0, 1'b0, 1'b1, 2'd3, 2'd1, 13'h0000, "R10 index 3 mask");
      look(21'h180000, "R10 ignored writes kept select 1");
      look(21'h1F2000, "R10 ignored writes kept select 0 off");

      cfg(2'd0, 2'd1, 13'h0000, "R10 mask 0 cleared");
      cfg(2'd0, 2'd2, 13'h0001, "R10 enable 0");
      look(21'h000123, "R2 open mask matches all");
      look(21'h17E000, "R7 open select 0 wins");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R9: %0d results never compared, expected 0", exp_q.size());
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule